// File: doc/BRIEF.md
# Overflow Interrupt Enable Register

This block holds the per-counter overflow interrupt enables of a performance-monitor unit and turns counter overflow flags into one interrupt request. The enable word has one bit for each of up to 31 event counters, held in bits 0 upward, and one bit for the cycle counter, held in the top bit (bit 31 at default parameters). Software reaches the shared enable state through two aliases. A write through the set alias turns on every bit written as 1. A write through the clear alias turns off every bit written as 1. Bits written as 0 keep their value under either alias, and both aliases read back the same enable word.

The number of event counters that exist is chosen at run time. At the guest privilege level (encoding 1), when the hypervisor level is present and enabled, the limit comes from a hypervisor partition count. In every other case it comes from the global counter count. Event bits at or above that limit read as zero, ignore writes, and cannot raise the interrupt. The cycle-counter bit is always implemented.

The access port has no back-pressure. It takes one access in any cycle where the valid strobe is high, so a set and a clear can never collide. Read data is a live view of the enable state and needs no handshake. The enable state resets to all zeros.

Top module: `ovf_irq_enable`

## Requirements
- R1: After reset, the read data is 0 and the interrupt output is 0.
- R2: A write through the clear alias (acc_sel_set = 0) clears each implemented bit written as 1, from the next cycle. Bits written as 0 keep their value.
- R3: A write through the set alias (acc_sel_set = 1) sets each implemented bit written as 1, from the next cycle. Bits written as 0 keep their value.
- R4: Read data shows the enable state masked to the implemented bits, whatever the alias select. An access with acc_write = 0 changes no bit.
- R5: The top bit, which belongs to the cycle counter, is readable, writable and can raise the interrupt for every counter limit, including a limit of 0.
- R6: For a counter limit N, event bits [30:N] read as 0. Writes to those bits are ignored, so they are still 0 when the limit is later raised.
- R7: The limit N is taken from lim_partition when priv_level = 2'd1 and hyp_enabled = 1. Otherwise N is taken from lim_global. A value above 31 is treated as 31.
- R8: irq_out is the OR over all bits of (ovf_flags AND enable AND implemented). It follows ovf_flags in the same cycle, with no register in the path.
- R9: When acc_valid is 0, the enable state does not change, whatever the other access inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the enable state |
| acc_valid | input | 1 | Access strobe; one access per cycle |
| acc_sel_set | input | 1 | Alias select: 1 = set alias, 0 = clear alias |
| acc_write | input | 1 | 1 = write access, 0 = read only |
| acc_wdata | input | 32 | Write data; a 1 marks a bit to set or clear |
| acc_rdata | output | 32 | Current enable word masked to the implemented bits |
| priv_level | input | 2 | Active privilege level; 2'd1 is the guest level |
| hyp_enabled | input | 1 | Hypervisor level present and enabled |
| lim_global | input | 5 | Global implemented event-counter count |
| lim_partition | input | 5 | Hypervisor partition event-counter count |
| ovf_flags | input | 32 | Overflow flags, same bit layout as the enable word |
| irq_out | output | 1 | Overflow interrupt request |

## Verification
A write is registered on the clock edge where it is presented. Its effect on the read data and on the interrupt is due one cycle later. A change to the limit inputs or to ovf_flags reaches acc_rdata and irq_out in the same cycle, through logic only. The bench drives inputs on falling edges, lets each write pass one rising edge, and compares outputs on the next falling edge. Limit and flag changes are compared a short settle delay after they are applied, with no clock edge in between.

// File: rtl/oie_pkg.sv
package oie_pkg;
  localparam int EVT_MAX   = 31;
  localparam int WORD_W    = EVT_MAX + 1;
  localparam int LIM_W     = $clog2(EVT_MAX + 1);
  localparam logic [1:0] PRIV_GUEST = 2'd1;
endpackage

// File: rtl/oie_limit.sv
module oie_limit #(
  parameter int EVT_CNT = 31,
  parameter int LIM_W   = $clog2(EVT_CNT + 1),
  localparam int WORD_W = EVT_CNT + 1
) (
  input  logic [1:0]        priv_level,
  input  logic              hyp_enabled,
  input  logic [LIM_W-1:0]  lim_global,
  input  logic [LIM_W-1:0]  lim_partition,
  output logic [LIM_W-1:0]  n_eff,
  output logic [WORD_W-1:0] impl_mask
);
  logic             use_part;
  logic [LIM_W-1:0] n_raw;

  assign use_part = (priv_level == oie_pkg::PRIV_GUEST) && hyp_enabled;
  assign n_raw    = use_part ? lim_partition : lim_global;
  assign n_eff    = (32'(n_raw) > EVT_CNT) ? LIM_W'(EVT_CNT) : n_raw;

  for (genvar i = 0; i < EVT_CNT; i++) begin : g_evt
    assign impl_mask[i] = (32'(n_eff) > i);
  end
  assign impl_mask[WORD_W-1] = 1'b1;
endmodule

// File: rtl/oie_state.sv
module oie_state #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              set_sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] impl_mask,
  output logic [WORD_W-1:0] state_q
);
  logic [WORD_W-1:0] hit;
  logic [WORD_W-1:0] state_d;

  assign hit = wdata & impl_mask;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      if (set_sel) state_d = state_q | hit;
      else         state_d = state_q & ~hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assert_clear_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !set_sel) |=> ((state_q & $past(wdata & impl_mask)) == '0));

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && set_sel) |=> ((state_q & $past(wdata & impl_mask)) == $past(wdata & impl_mask)));

  assert_unimpl_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((state_q ^ $past(state_q)) & ~$past(impl_mask)) == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_q));
endmodule

// File: rtl/oie_irq.sv
module oie_irq #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] enables,
  input  logic [WORD_W-1:0] flags,
  output logic              irq
);
  assign irq = |(enables & flags);
endmodule

// File: rtl/ovf_irq_enable.sv
module ovf_irq_enable #(
  parameter int EVT_CNT = oie_pkg::EVT_MAX,
  localparam int WORD_W = EVT_CNT + 1,
  localparam int LIM_W  = $clog2(EVT_CNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_sel_set,
  input  logic              acc_write,
  input  logic [WORD_W-1:0] acc_wdata,
  output logic [WORD_W-1:0] acc_rdata,
  input  logic [1:0]        priv_level,
  input  logic              hyp_enabled,
  input  logic [LIM_W-1:0]  lim_global,
  input  logic [LIM_W-1:0]  lim_partition,
  input  logic [WORD_W-1:0] ovf_flags,
  output logic              irq_out
);
  logic [LIM_W-1:0]  n_eff;
  logic [WORD_W-1:0] impl_mask;
  logic [WORD_W-1:0] state_q;
  logic [WORD_W-1:0] visible;

  oie_limit #(.EVT_CNT(EVT_CNT), .LIM_W(LIM_W)) u_limit (
    .priv_level   (priv_level),
    .hyp_enabled  (hyp_enabled),
    .lim_global   (lim_global),
    .lim_partition(lim_partition),
    .n_eff        (n_eff),
    .impl_mask    (impl_mask)
  );

  oie_state #(.WORD_W(WORD_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc_valid && acc_write),
    .set_sel  (acc_sel_set),
    .wdata    (acc_wdata),
    .impl_mask(impl_mask),
    .state_q  (state_q)
  );

  assign visible   = state_q & impl_mask;
  assign acc_rdata = visible;

  oie_irq #(.WORD_W(WORD_W)) u_irq (
    .enables(visible),
    .flags  (ovf_flags),
    .irq    (irq_out)
  );

  assert_hi_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rdata[EVT_CNT-1:0] >> n_eff) == '0));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((ovf_flags & acc_rdata) != '0));

  assert_cycle_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_sel_set && acc_wdata[WORD_W-1]) |=> acc_rdata[WORD_W-1]);
endmodule

// File: tb/ovf_irq_enable_bench.sv
module ovf_irq_enable_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_sel_set = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [1:0]  priv_level = 2'd0;
  logic        hyp_enabled = 1'b0;
  logic [4:0]  lim_global = 5'd31;
  logic [4:0]  lim_partition = 5'd31;
  logic [31:0] ovf_flags = '0;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ovf_irq_enable u_ovf_irq_enable (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel_set(acc_sel_set),
    .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .priv_level(priv_level), .hyp_enabled(hyp_enabled), .lim_global(lim_global),
    .lim_partition(lim_partition), .ovf_flags(ovf_flags), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] wdata;
    logic [31:0] ovf;
    logic [31:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{2'd1, 32'h8000_0001, 32'h0000_0001, 32'h8000_0001, 1'b1},
    '{2'd1, 32'h0000_00F0, 32'h4000_0000, 32'h8000_00F1, 1'b0},
    '{2'd2, 32'h0000_0011, 32'h0000_0001, 32'h8000_00E0, 1'b0},
    '{2'd2, 32'h8000_0000, 32'h8000_0000, 32'h0000_00E0, 1'b0},
    '{2'd1, 32'h7FFF_0000, 32'h0001_0000, 32'h7FFF_00E0, 1'b1},
    '{2'd2, 32'h0000_0000, 32'h0000_0000, 32'h7FFF_00E0, 1'b0},
    '{2'd1, 32'h0000_0000, 32'hFFFF_FFFF, 32'h7FFF_00E0, 1'b1},
    '{2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{2'd1, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1},
    '{2'd2, 32'h5555_5555, 32'h5555_5555, 32'hAAAA_AAAA, 1'b0}
  };

  task automatic chk_rd(input string req, input logic [31:0] exp);
    n_chk++;
    if (acc_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s rdata actual=%h expected=%h", req, acc_rdata, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    n_chk++;
    if (irq_out !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq_out, exp);
    end
  endtask

  // Drives one access at a falling edge; it is registered on the next rising
  // edge, and the task returns at the falling edge after, where outputs are due.
  task automatic access(input logic v, input logic wr, input logic set, input logic [31:0] d);
    @(negedge clk);
    acc_valid = v; acc_write = wr; acc_sel_set = set; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    ovf_flags = 32'hFFFF_FFFF;
    #1;
    chk_rd("R1", 32'h0);
    chk_irq("R1", 1'b0);
    ovf_flags = '0;

    // Vector walk at full limit: R2 clear, R3 set, R8 interrupt
    for (int k = 0; k < 10; k++) begin
      access(1'b1, 1'b1, VECS[k].op == 2'd1, VECS[k].wdata);
      ovf_flags = VECS[k].ovf;
      #1;
      chk_rd(VECS[k].op == 2'd1 ? "R3" : "R2", VECS[k].exp_rd);
      chk_irq("R8", VECS[k].exp_irq);
      ovf_flags = '0;
    end

    // R4: state is AAAAAAAA; both alias selects read it, read-only changes nothing
    access(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
    acc_sel_set = 1'b1; #1;
    chk_rd("R4", 32'hAAAA_AAAA);
    acc_sel_set = 1'b0; #1;
    chk_rd("R4", 32'hAAAA_AAAA);
    access(1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
    chk_rd("R4", 32'hAAAA_AAAA);

    // R9: valid low, write and data driven, nothing changes
    access(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    chk_rd("R9", 32'hAAAA_AAAA);
    access(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    chk_rd("R9", 32'hAAAA_AAAA);

    // R6: global limit 4 hides bits [30:4]
    lim_global = 5'd4; #1;
    chk_rd("R6", 32'h8000_000A);
    access(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
    chk_rd("R6", 32'h8000_000F);
    ovf_flags = 32'h0000_0020; #1;
    chk_irq("R6", 1'b0);
    ovf_flags = 32'h0000_0004; #1;
    chk_irq("R8", 1'b1);
    ovf_flags = '0;

    // R6: a write above the limit is ignored, seen after raising the limit
    do_reset();
    chk_rd("R1", 32'h0);
    lim_global = 5'd2;
    access(1'b1, 1'b1, 1'b1, 32'h0000_000C);
    lim_global = 5'd31; #1;
    chk_rd("R6", 32'h0000_0000);

    // R7: limit source selection
    priv_level = 2'd2; hyp_enabled = 1'b1; lim_partition = 5'd3;
    access(1'b1, 1'b1, 1'b1, 32'h0000_00FF);
    chk_rd("R7", 32'h0000_00FF);
    priv_level = 2'd1; #1;
    chk_rd("R7", 32'h0000_0007);
    hyp_enabled = 1'b0; #1;
    chk_rd("R7", 32'h0000_00FF);
    priv_level = 2'd0; hyp_enabled = 1'b1; #1;
    chk_rd("R7", 32'h0000_00FF);

    // R5: cycle-counter bit at limit 0
    lim_global = 5'd0; #1;
    chk_rd("R5", 32'h0000_0000);
    access(1'b1, 1'b1, 1'b1, 32'h8000_0001);
    chk_rd("R5", 32'h8000_0000);
    ovf_flags = 32'h8000_0000; #1;
    chk_irq("R5", 1'b1);
    access(1'b1, 1'b1, 1'b0, 32'h8000_0000);
    chk_rd("R5", 32'h0000_0000);
    chk_irq("R5", 1'b0);
    ovf_flags = '0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule